// File: doc/BRIEF.md
# Interleaved Cache-Line Fetcher

This block refills one cache line from a set of word-interleaved memory banks. Word k of a line sits in bank k. When a miss request is accepted, the fetcher aligns the word address down to a line boundary. It then sends that line address to every bank in a single cycle, and all banks carry out their accesses at the same time. After that, the words come back one per cycle, in ascending word order, on a stream marked by valid and last.

The project contains the bank models. Each bank model has a fixed access latency and computes its contents from the address, so the block can be checked with nothing outside it. The refill latency is one address cycle, plus the bank latency, plus one cycle per word. With the defaults (4 banks, latency 6) this is 11 cycles. The fetcher holds one line at a time. A request that arrives while a line is in flight waits until the fetcher can take it, and is not lost.

Top module: `ilf_block_fetcher`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `miss_ready` is 1, and `word_valid`, `word_last` and `done` are all 0. This also applies when reset is applied in the middle of a refill.
- R2: The two low bits of `miss_addr` are ignored. The line base is `miss_addr` with bits [1:0] forced to 0. Word k of the line is the word at address base+k.
- R3: A bank holds the word at address a as the value {a XOR 16'hAAAA, a}, with the upper 16 bits first. Once its access completes, a bank holds its word steady until it is given a new address.
- R4: Take the clock edge that accepts a request (`miss_req` and `miss_ready` both 1) as edge 0. Word k is then on the output after edge BANK_LAT+1+k. The last word appears in cycle 1+BANK_LAT+NUM_BANKS, counted from acceptance, which is cycle 11 with the defaults.
- R5: `word_valid` is high for exactly NUM_BANKS consecutive cycles per line. `word_idx` counts 0,1,2,3 during those cycles and `word_data` carries word `word_idx`.
- R6: `word_last` and `done` are both high on the final word of the line and only on that word.
- R7: `busy` goes high after the accepting edge and stays high until after the final word. `miss_ready` is the inverse of `busy`.
- R8: A request raised while `busy` is high is not accepted and does not disturb the line in flight. If the request is held, it is accepted at the first edge where `miss_ready` is 1, and its line is then returned in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_req | input | 1 | Miss request, held by the requester until accepted |
| miss_addr | input | ADDR_W (16) | Word address of the miss |
| miss_ready | output | 1 | A request is taken at this edge |
| busy | output | 1 | A line refill is in progress |
| word_valid | output | 1 | `word_data` holds a line word |
| word_data | output | 2*ADDR_W (32) | Returned word |
| word_idx | output | 2 | Position of the word within the line |
| word_last | output | 1 | Final word of the line |
| done | output | 1 | Refill completes in this cycle |

## Verification
The main path is run with aligned line addresses, with addresses whose low bits are not zero, and with an address in the top line of the address space, where base+k must not carry past the top. Aligned addresses check the ordering of the words and the bank data. Unaligned addresses show whether the low bits are really discarded, as opposed to used as an offset. The top-of-space line shows whether each bank builds its address from the line base rather than by adding to it. A request held while busy, a reset in the middle of a refill, and a cycle count from acceptance to the last word cover stalling, recovery and the 11-cycle latency.

// File: rtl/ilf_pkg.sv
package ilf_pkg;
    // Refill sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_XFER = 2'd3
    } ilf_state_e;
endpackage

// File: rtl/ilf_bank_model.sv
// Behavioural bank: takes an address on cap, presents its word after LAT
// cycles, and holds it until the next cap. Contents are computed from
// the address, so no storage array is needed. Assumes LAT >= 1.
module ilf_bank_model #(
    parameter int ADDR_W = 16,
    parameter int LAT    = 6,
    localparam int DATA_W = 2 * ADDR_W,
    localparam int CNT_W  = $clog2(LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] PAT = {(ADDR_W/2){2'b10}};

    logic [CNT_W-1:0]  cnt_q;
    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;

    // Capture the address and count down the access latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            addr_q <= '0;
        end else if (cap) begin
            cnt_q  <= CNT_W'(LAT - 1);
            pend_q <= 1'b1;
            addr_q <= addr;
        end else if (pend_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Word becomes visible once the countdown has expired
    always_comb begin
        ready = pend_q && (cnt_q == '0);
        rdata = {addr_q ^ PAT, addr_q};
    end

    // R3
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !cap |=> ready && $stable(rdata));
endmodule

// File: rtl/ilf_fetch_ctrl.sv
// Refill sequencer: accepts a miss when idle, spends one cycle sending the
// line base to the banks, waits for every bank, then steps a word index
// through the line once per cycle. Assumes NUM_BANKS is a power of two >= 2.
module ilf_fetch_ctrl
    import ilf_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    localparam int IDX_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              all_ready,
    output logic              ready,
    output logic              busy,
    output logic              bank_cap,
    output logic [ADDR_W-1:0] base,
    output logic              xfer_valid,
    output logic              xfer_last,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

    ilf_state_e       state_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;

    // Phase sequencing, line base capture and word index stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req) begin
                    base_q  <= {addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
                    state_q <= ST_ADDR;
                end
                ST_ADDR: state_q <= ST_WAIT;
                ST_WAIT: if (all_ready) begin
                    idx_q   <= '0;
                    state_q <= ST_XFER;
                end
                ST_XFER: begin
                    if (idx_q == LAST_IDX) state_q <= ST_IDLE;
                    else                   idx_q   <= idx_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode phase into handshake and stream controls
    always_comb begin
        ready      = (state_q == ST_IDLE);
        busy       = (state_q != ST_IDLE);
        bank_cap   = (state_q == ST_ADDR);
        base       = base_q;
        xfer_valid = (state_q == ST_XFER);
        xfer_last  = (state_q == ST_XFER) && (idx_q == LAST_IDX);
        idx        = idx_q;
    end

    // R4
    banks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> all_ready);
    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_last |=> xfer_valid && idx == $past(idx) + 1'b1);
    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && ready |=> busy);
    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_last |=> !busy);
endmodule

// File: rtl/ilf_word_mux.sv
// Output stage: picks the word of the bank named by the index and zeroes
// the data bus outside the transfer window. Purely combinational.
module ilf_word_mux #(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_BANKS)
) (
    input  logic [DATA_W-1:0] bank_data [NUM_BANKS],
    input  logic [IDX_W-1:0]  idx,
    input  logic              valid,
    output logic [DATA_W-1:0] data
);
    // Select the current bank word
    always_comb begin
        data = valid ? bank_data[idx] : '0;
    end
endmodule

// File: rtl/ilf_block_fetcher.sv
// Line refill from NUM_BANKS word-interleaved banks. Word k of a line lives
// in bank k; all banks access together, words return one per cycle.
// Assumes the requester holds miss_req and miss_addr until miss_ready.
module ilf_block_fetcher #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    parameter int BANK_LAT  = 6,
    localparam int DATA_W   = 2 * ADDR_W,
    localparam int IDX_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_req,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_ready,
    output logic              busy,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data,
    output logic [IDX_W-1:0]  word_idx,
    output logic              word_last,
    output logic              done
);
    logic                 bank_cap;
    logic [ADDR_W-1:0]    base;
    logic [NUM_BANKS-1:0] bank_rdy;
    logic [DATA_W-1:0]    bank_data [NUM_BANKS];
    logic                 xfer_valid;
    logic                 xfer_last;
    logic [IDX_W-1:0]     idx;

    ilf_fetch_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(miss_req), .addr(miss_addr),
        .all_ready(&bank_rdy), .ready(miss_ready), .busy(busy),
        .bank_cap(bank_cap), .base(base), .xfer_valid(xfer_valid),
        .xfer_last(xfer_last), .idx(idx)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [ADDR_W-1:0] bank_addr;
        // Bank b serves word b of the line
        always_comb bank_addr = {base[ADDR_W-1:IDX_W], IDX_W'(b)};

        ilf_bank_model #(.ADDR_W(ADDR_W), .LAT(BANK_LAT)) u_bank (
            .clk(clk), .rst_n(rst_n), .cap(bank_cap), .addr(bank_addr),
            .ready(bank_rdy[b]), .rdata(bank_data[b])
        );
    end

    ilf_word_mux #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_mux (
        .bank_data(bank_data), .idx(idx), .valid(xfer_valid), .data(word_data)
    );

    // Drive the stream flags
    always_comb begin
        word_valid = xfer_valid;
        word_idx   = idx;
        word_last  = xfer_last;
        done       = xfer_last;
    end

    // R6
    last_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_last |-> word_valid && busy);
    // R7
    ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !word_valid);
endmodule

// File: tb/sim_ilf_block_fetcher.sv
`timescale 1ns/1ps
module sim_ilf_block_fetcher;
    localparam int N   = 4;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_req = 1'b0;
    logic [15:0] miss_addr = '0;
    logic        miss_ready, busy, word_valid, word_last, done;
    logic [31:0] word_data;
    logic [1:0]  word_idx;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ilf_block_fetcher u0 (
        .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_addr(miss_addr),
        .miss_ready(miss_ready), .busy(busy), .word_valid(word_valid),
        .word_data(word_data), .word_idx(word_idx), .word_last(word_last),
        .done(done)
    );

    // Stimulus address and expected line base
    typedef struct packed { logic [15:0] addr; logic [15:0] base; } vec_t;
    localparam vec_t VEC [6] = '{
        '{16'h0000, 16'h0000}, '{16'h0040, 16'h0040}, '{16'h0013, 16'h0010},
        '{16'h1236, 16'h1234}, '{16'hFFFF, 16'hFFFC}, '{16'h8001, 16'h8000}};

    function automatic logic [31:0] exp_word(logic [15:0] a);
        return {a ^ 16'hAAAA, a};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at the negedge just after the accepting edge; walks the refill
    task automatic run_line(logic [15:0] base, bit stall, logic [15:0] nxt);
        int last_c = -1;
        miss_req = 1'b0;
        chk("R7 busy after accept", {busy, miss_ready}, 2'b10);
        for (int c = 1; c <= LAT + N; c++) begin
            if (stall && c == 3) begin
                miss_req = 1'b1;
                miss_addr = nxt;
            end
            @(negedge clk);
            if (c >= LAT + 1) begin
                int k = c - LAT - 1;
                chk("R5 valid", word_valid, 1);
                chk("R5 index", word_idx, k);
                chk("R2 R3 data", word_data, exp_word(base + 16'(k)));
                chk("R6 last/done", {word_last, done}, (k == N - 1) ? 2'b11 : 2'b00);
                if (word_last) last_c = c;
            end else begin
                chk("R4 no early word", word_valid, 0);
            end
            chk("R7 busy during refill", {busy, miss_ready}, 2'b10);
            if (stall) chk("R8 stalled not taken", busy, 1);
        end
        chk("R4 cycles to last word", last_c + 1, 1 + LAT + N);
        @(negedge clk);
        chk("R7 released", {busy, miss_ready, word_valid}, 3'b010);
    endtask

    task automatic issue(logic [15:0] a);
        miss_addr = a;
        miss_req  = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", {busy, miss_ready, word_valid, word_last, done}, 5'b01000);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk of line refills
        foreach (VEC[i]) begin
            issue(VEC[i].addr);
            run_line(VEC[i].base, 1'b0, '0);
        end

        // Held request during a refill is taken afterwards
        issue(16'h0100);
        run_line(16'h0100, 1'b1, 16'h0207);
        chk("R8 held request pending", miss_req, 1);
        @(negedge clk);
        run_line(16'h0204, 1'b0, '0);

        // Reset in the middle of a transfer
        issue(16'h0300);
        repeat (LAT + 2) @(negedge clk);
        chk("R5 mid transfer", word_valid, 1);
        miss_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid refill", {busy, miss_ready, word_valid, done}, 4'b0100);
        rst_n = 1'b1;
        @(negedge clk);
        issue(16'h0402);
        run_line(16'h0400, 1'b0, '0);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule